// File: doc/BRIEF.md
# Interrupt Priority Rotation and EOI Unit

This block resolves priority among eight interrupt request lines and tracks which levels are in service. Each line is latched either on a rising edge or as a plain level, as chosen by a mode input. The interrupt output rises when some latched request outranks every level now in service. A one-cycle acknowledge strobe reports the index of the winning level and moves that level from pending to in service.

Priority is not fixed. The unit keeps a single "lowest-priority level" pointer, and the ranking runs upward from the level after it, modulo 8. An 8-bit write-only command word ends interrupts, either for the top in-service level or for a named one. It can also rotate the priority order, name the lowest level directly, or set and clear a flag. With auto end-of-interrupt on, that flag makes each acknowledge rotate the order. The unit sits beside a processor bus, which writes the command word and pulses the acknowledge.

Top module: `irq_rotate_unit`

## Requirements
- R1: After reset, irq_out is 0 and isr_out is 0. Level 0 has the highest priority and level 7 the lowest (the lowest-priority pointer is 7). The rotate-on-auto-EOI flag is clear.
- R2: With trig_level=0, a request is latched on a 0-to-1 change of its req bit and stays latched until acknowledged. With trig_level=1, the latch follows req each cycle. A request latches on the clock edge after req changes.
- R3: The rank of level L is (L - P - 1) mod 8, where P is the lowest-priority pointer and rank 0 is the highest. irq_out is 1 exactly when some latched level has a smaller rank than every in-service level, or when at least one level is latched and none is in service.
- R4: While irq_out is 1, ack_level gives the latched level of smallest rank. An ack pulse then clears that level's latch and sets its isr_out bit. An ack while irq_out is 0 changes nothing.
- R5: A write (cmd_we=1) is accepted only when cmd_data[4:3]=00. Any other value changes neither isr_out nor the priority order.
- R6: Code cmd_data[7:5]=001 clears the isr_out bit of the in-service level of smallest rank. Code 011 clears the isr_out bit of the level in cmd_data[2:0], if that bit is set.
- R7: Code 101 acts as 001 and code 111 acts as 011, and each also sets the pointer to the level just cleared, which makes that level the lowest.
- R8: Code 110 sets the pointer to cmd_data[2:0] and leaves isr_out unchanged.
- R9: Code 100 sets the rotate-on-auto-EOI flag and code 000 clears it. While auto_eoi=1, an acknowledge leaves isr_out unchanged. If the flag is also set, the acknowledge sets the pointer to the acknowledged level.
- R10: Code 010 changes nothing. Codes 001, 011, 101 and 111 change nothing, including the pointer, when they find no matching in-service bit to clear. cmd_data[2:0] has no effect on codes 000, 001, 010, 100 and 101.
- R11: If an accepted command and an ack pulse fall in the same cycle, the command takes effect and the ack is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_level | input | 1 | 1 = level-sensitive request latching, 0 = rising-edge latching |
| auto_eoi | input | 1 | 1 = acknowledge does not leave the level in service |
| req | input | 8 | Interrupt request lines, bit index = level |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command word: [7:5] code, [4:3] select (must be 00), [2:0] level |
| ack | input | 1 | One-cycle acknowledge strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_level | output | 3 | Index of the winning pending level |
| isr_out | output | 8 | In-service bits, bit index = level |

## Verification
The bench drives rotations and set-priority commands so that the order of acknowledges shows where the pointer sits. A design that rotated on a plain EOI, or on an EOI that found nothing in service, would grant a different level next. It sends command words with a non-zero select field and words whose level field should be ignored, and checks that the in-service bits and the order stay put. It issues acknowledges in auto-EOI mode with the rotate flag both set and clear, and places an acknowledge in the same cycle as a command. It also holds level-mode requests across an EOI to show that they re-raise the interrupt, while edge-mode requests do not. A random phase compares every output with a behavioural model on every cycle.

// File: rtl/irq_rot_pkg.sv
package irq_rot_pkg;

  typedef enum logic [2:0] {
    OP_AEOI_CLR = 3'b000,
    OP_NS_EOI   = 3'b001,
    OP_NOP      = 3'b010,
    OP_SP_EOI   = 3'b011,
    OP_AEOI_SET = 3'b100,
    OP_ROT_NS   = 3'b101,
    OP_SET_PRI  = 3'b110,
    OP_ROT_SP   = 3'b111
  } cmd_op_e;

  typedef struct packed {
    logic    valid;
    cmd_op_e op;
    logic [2:0] lvl;
  } cmd_t;

endpackage

// File: rtl/irq_rot_rst_sync.sv
module irq_rot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain[STAGES-1];

endmodule

// File: rtl/irq_rot_decode.sv
module irq_rot_decode
  import irq_rot_pkg::*;
(
  input  logic       we_i,
  input  logic [7:0] data_i,
  output cmd_t       cmd_o
);

  always_comb begin
    cmd_o.valid = we_i && (data_i[4:3] == 2'b00);
    cmd_o.op    = cmd_op_e'(data_i[7:5]);
    cmd_o.lvl   = data_i[2:0];
  end

endmodule

// File: rtl/irq_rot_resolve.sv
module irq_rot_resolve #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] irr_i,
  input  logic [NUM_LVL-1:0] isr_i,
  input  logic [LVL_W-1:0]   low_ptr_i,
  output logic               req_any_o,
  output logic [LVL_W-1:0]   req_lvl_o,
  output logic               isr_any_o,
  output logic [LVL_W-1:0]   isr_lvl_o,
  output logic               irq_o
);

  logic [LVL_W-1:0] lvl_at [NUM_LVL];
  logic [LVL_W-1:0] req_rank;
  logic [LVL_W-1:0] isr_rank;

  function automatic logic [LVL_W-1:0] wrap_lvl(input int s);
    int t;
    t = s;
    if (t >= NUM_LVL) t = t - NUM_LVL;
    return LVL_W'(t);
  endfunction

  // level sitting at each rank, rank 0 first
  for (genvar k = 0; k < NUM_LVL; k++) begin : g_rank
    assign lvl_at[k] = wrap_lvl(int'(low_ptr_i) + 1 + k);
  end

  always_comb begin
    req_any_o = 1'b0;
    req_lvl_o = '0;
    req_rank  = '0;
    for (int k = NUM_LVL - 1; k >= 0; k--) begin
      if (irr_i[lvl_at[k]]) begin
        req_any_o = 1'b1;
        req_lvl_o = lvl_at[k];
        req_rank  = LVL_W'(k);
      end
    end
  end

  always_comb begin
    isr_any_o = 1'b0;
    isr_lvl_o = '0;
    isr_rank  = '0;
    for (int k = NUM_LVL - 1; k >= 0; k--) begin
      if (isr_i[lvl_at[k]]) begin
        isr_any_o = 1'b1;
        isr_lvl_o = lvl_at[k];
        isr_rank  = LVL_W'(k);
      end
    end
  end

  assign irq_o = req_any_o && (!isr_any_o || (req_rank < isr_rank));

endmodule

// File: rtl/irq_rotate_unit.sv
module irq_rotate_unit
  import irq_rot_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_level,
  input  logic               auto_eoi,
  input  logic [NUM_LVL-1:0] req,
  input  logic               cmd_we,
  input  logic [7:0]         cmd_data,
  input  logic               ack,
  output logic               irq_out,
  output logic [LVL_W-1:0]   ack_level,
  output logic [NUM_LVL-1:0] isr_out
);

  logic               rst_s_n;
  cmd_t               cmd;
  logic [NUM_LVL-1:0] irr_q, irr_n;
  logic [NUM_LVL-1:0] isr_q, isr_n;
  logic [NUM_LVL-1:0] req_q;
  logic [LVL_W-1:0]   low_ptr, ptr_n;
  logic               rot_flag, flag_n;
  logic               req_any, isr_any, irq;
  logic [LVL_W-1:0]   req_lvl, isr_lvl, cmd_lvl;
  logic               take_ack, state_en;

  irq_rot_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  irq_rot_decode i_decode (
    .we_i   (cmd_we),
    .data_i (cmd_data),
    .cmd_o  (cmd)
  );

  irq_rot_resolve #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) i_resolve (
    .irr_i     (irr_q),
    .isr_i     (isr_q),
    .low_ptr_i (low_ptr),
    .req_any_o (req_any),
    .req_lvl_o (req_lvl),
    .isr_any_o (isr_any),
    .isr_lvl_o (isr_lvl),
    .irq_o     (irq)
  );

  assign cmd_lvl  = LVL_W'(cmd.lvl);
  assign take_ack = ack && irq && !cmd.valid;
  assign state_en = take_ack || cmd.valid;

  always_comb begin
    irr_n  = trig_level ? req : (irr_q | (req & ~req_q));
    isr_n  = isr_q;
    ptr_n  = low_ptr;
    flag_n = rot_flag;
    if (take_ack) begin
      irr_n[req_lvl] = 1'b0;
      if (!auto_eoi)     isr_n[req_lvl] = 1'b1;
      else if (rot_flag) ptr_n = req_lvl;
    end
    if (cmd.valid) begin
      case (cmd.op)
        OP_AEOI_CLR: flag_n = 1'b0;
        OP_AEOI_SET: flag_n = 1'b1;
        OP_NS_EOI, OP_ROT_NS: begin
          if (isr_any) begin
            isr_n[isr_lvl] = 1'b0;
            if (cmd.op == OP_ROT_NS) ptr_n = isr_lvl;
          end
        end
        OP_SP_EOI, OP_ROT_SP: begin
          if (isr_q[cmd_lvl]) begin
            isr_n[cmd_lvl] = 1'b0;
            if (cmd.op == OP_ROT_SP) ptr_n = cmd_lvl;
          end
        end
        OP_SET_PRI: ptr_n = cmd_lvl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irr_q <= '0;
      req_q <= '0;
    end else begin
      irr_q <= irr_n;
      req_q <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      isr_q    <= '0;
      low_ptr  <= LVL_W'(NUM_LVL - 1);
      rot_flag <= 1'b0;
    end else if (state_en) begin
      isr_q    <= isr_n;
      low_ptr  <= ptr_n;
      rot_flag <= flag_n;
    end
  end

  assign irq_out   = irq;
  assign ack_level = req_lvl;
  assign isr_out   = isr_q;

  // R5: a word with a non-zero select field touches neither state
  a_r5_select_ignored: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_we && (cmd_data[4:3] != 2'b00) && !ack) |=> ($stable(isr_q) && $stable(low_ptr)));

  // R4: a taken acknowledge marks its level in service
  a_r4_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ack && irq_out && !auto_eoi && !cmd_we) |=> isr_out[$past(ack_level)]);

  // R6: one cycle never ends more than one level
  a_r6_one_eoi: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> ($countones($past(isr_q) & ~isr_q) <= 1));

  // R3: nothing in service and something latched means an interrupt
  a_r3_idle_raises: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((isr_q == '0) && (irr_q != '0)) |-> irq_out);

  // R9: in auto-EOI mode an acknowledge adds no in-service bit
  a_r9_aeoi_no_isr: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ack && auto_eoi) |=> ($countones(isr_q) <= $countones($past(isr_q))));

  // R4: the reported level is really pending
  a_r4_lvl_pending: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_out |-> irr_q[ack_level]);

endmodule

// File: tb/test_irq_rotate_unit.sv
`timescale 1ns/1ps
module test_irq_rotate_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig_level, auto_eoi, cmd_we, ack;
  logic [7:0] req, cmd_data;
  logic       irq_out;
  logic [2:0] ack_level;
  logic [7:0] isr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int last_ack;

  // reference state
  logic [7:0] m_irr, m_isr, m_prev;
  int         m_low;
  bit         m_flag;

  always #4 clk = ~clk;

  irq_rotate_unit i_irq_rotate_unit (
    .clk(clk), .rst_n(rst_n), .trig_level(trig_level), .auto_eoi(auto_eoi),
    .req(req), .cmd_we(cmd_we), .cmd_data(cmd_data), .ack(ack),
    .irq_out(irq_out), .ack_level(ack_level), .isr_out(isr_out)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int rank(input int lvl);
    return (lvl - m_low - 1 + 16) % 8;
  endfunction

  function automatic int top_of(input logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      int lvl;
      lvl = (m_low + 1 + k) % 8;
      if (v[lvl]) return lvl;
    end
    return -1;
  endfunction

  task automatic step(input logic [7:0] r, input bit we, input logic [7:0] d,
                      input bit a, input string tag);
    int ph, ih, lv;
    bit e_irq, valid, taken;
    logic [7:0] nirr;
    req = r; cmd_we = we; cmd_data = d; ack = a;
    #1;
    ph = top_of(m_irr);
    ih = top_of(m_isr);
    e_irq = (ph >= 0) && ((ih < 0) || (rank(ph) < rank(ih)));
    chk(irq_out === e_irq, {tag, " irq_out"}, int'(irq_out), int'(e_irq));
    chk(isr_out === m_isr, {tag, " isr_out"}, int'(isr_out), int'(m_isr));
    if (a && e_irq) begin
      chk(ack_level === ph[2:0], {tag, " ack_level"}, int'(ack_level), ph);
      last_ack = int'(ack_level);
    end
    valid = we && (d[4:3] == 2'b00);
    taken = a && e_irq && !valid;
    nirr  = trig_level ? r : (m_irr | (r & ~m_prev));
    m_prev = r;
    if (taken) begin
      nirr[ph] = 1'b0;
      if (!auto_eoi) m_isr[ph] = 1'b1;
      else if (m_flag) m_low = ph;
    end
    m_irr = nirr;
    if (valid) begin
      lv = int'(d[2:0]);
      case (d[7:5])
        3'b000: m_flag = 0;
        3'b100: m_flag = 1;
        3'b001, 3'b101: if (ih >= 0) begin
          m_isr[ih] = 1'b0;
          if (d[7]) m_low = ih;
        end
        3'b011, 3'b111: if (m_isr[lv]) begin
          m_isr[lv] = 1'b0;
          if (d[7]) m_low = lv;
        end
        3'b110: m_low = lv;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [7:0] r, input string tag);
    step(r, 0, 8'h00, 0, tag);
  endtask

  task automatic expect_out(input logic [7:0] e_isr, input bit e_irq, input string tag);
    #1;
    chk(isr_out === e_isr, {tag, " isr_out"}, int'(isr_out), int'(e_isr));
    chk(irq_out === e_irq, {tag, " irq_out"}, int'(irq_out), int'(e_irq));
  endtask

  task automatic expect_ack(input int e, input string tag);
    chk(last_ack == e, {tag, " granted level"}, last_ack, e);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; trig_level = 0; auto_eoi = 0; cmd_we = 0; ack = 0;
    req = 0; cmd_data = 0; last_ack = -1;
    m_irr = 0; m_isr = 0; m_prev = 0; m_low = 7; m_flag = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    expect_out(8'h00, 0, "R1 reset");

    // R4 / R3: grant order and nesting
    idle(8'h24, "R2 latch");
    step(8'h24, 0, 8'h00, 1, "R4 ack");
    expect_ack(2, "R4");
    expect_out(8'h04, 0, "R3 lower level blocked");
    step(8'h24, 1, 8'h20, 0, "R6 nonspecific");
    expect_out(8'h00, 1, "R6 after nonspecific EOI");
    step(8'h24, 0, 8'h00, 1, "R4 ack");
    expect_ack(5, "R4");
    step(8'h24, 1, 8'h28, 0, "R5 select");
    expect_out(8'h20, 0, "R5 select field nonzero");
    step(8'h24, 1, 8'h65, 0, "R6 specific");
    expect_out(8'h00, 0, "R6 specific EOI level 5");

    // R7: rotate on nonspecific EOI
    idle(8'h00, "R7");
    idle(8'h08, "R7");
    step(8'h08, 0, 8'h00, 1, "R7 ack");
    expect_ack(3, "R7");
    step(8'h08, 1, 8'hA0, 0, "R7 rotate");
    idle(8'h00, "R7");
    idle(8'h14, "R7");
    step(8'h14, 0, 8'h00, 1, "R7 ack");
    expect_ack(4, "R7 level after rotated one");
    step(8'h14, 1, 8'h20, 0, "R6");
    step(8'h14, 0, 8'h00, 1, "R7 ack");
    expect_ack(2, "R7");

    // R8: set priority keeps in-service bits
    step(8'h14, 1, 8'hC6, 0, "R8 set priority");
    expect_out(8'h04, 0, "R8 isr untouched");
    step(8'h14, 1, 8'h20, 0, "R6");
    idle(8'h00, "R8");
    idle(8'h81, "R8");
    step(8'h81, 0, 8'h00, 1, "R8 ack");
    expect_ack(7, "R8 level after named one");
    step(8'h81, 1, 8'hE7, 0, "R7 rotate specific");
    expect_out(8'h00, 1, "R7 rotate specific cleared");
    step(8'h81, 0, 8'h00, 1, "R7 ack");
    expect_ack(0, "R7 pointer back to 7");
    step(8'h81, 1, 8'h20, 0, "R6");

    // R10: empty EOI and NOP leave order alone
    step(8'h00, 1, 8'hA0, 0, "R10 empty rotate");
    step(8'h00, 1, 8'h47, 0, "R10 nop");
    idle(8'h81, "R10");
    step(8'h81, 0, 8'h00, 1, "R10 ack");
    expect_ack(0, "R10 order unchanged");
    step(8'h81, 1, 8'h27, 0, "R10 level bits ignored");
    expect_out(8'h00, 1, "R10 nonspecific with level bits");
    step(8'h81, 0, 8'h00, 1, "R10 ack");
    expect_ack(7, "R10");
    step(8'h81, 1, 8'h20, 0, "R6");

    // R9: auto-EOI with and without rotation flag
    auto_eoi = 1;
    step(8'h00, 1, 8'h80, 0, "R9 flag set");
    idle(8'h03, "R9");
    step(8'h03, 0, 8'h00, 1, "R9 ack");
    expect_ack(0, "R9");
    expect_out(8'h00, 1, "R9 no isr in auto EOI");
    step(8'h03, 0, 8'h00, 1, "R9 ack");
    expect_ack(1, "R9");
    step(8'h00, 1, 8'h00, 0, "R9 flag clear");
    idle(8'h05, "R9");
    step(8'h05, 0, 8'h00, 1, "R9 ack");
    expect_ack(2, "R9 rotated by flag");
    step(8'h05, 0, 8'h00, 1, "R9 ack");
    expect_ack(0, "R9");
    idle(8'h00, "R9");
    idle(8'h05, "R9");
    step(8'h05, 0, 8'h00, 1, "R9 ack");
    expect_ack(2, "R9 no rotation with flag clear");
    step(8'h05, 0, 8'h00, 1, "R9 ack");
    auto_eoi = 0;

    // R11: command and ack in the same cycle
    idle(8'h00, "R11");
    idle(8'h10, "R11");
    step(8'h10, 1, 8'h40, 1, "R11 collide");
    expect_out(8'h00, 1, "R11 ack ignored");
    step(8'h10, 0, 8'h00, 1, "R11 ack");
    expect_ack(4, "R11");
    step(8'h10, 1, 8'h20, 0, "R6");

    // R2: level mode re-raises, edge mode does not
    trig_level = 1;
    idle(8'h40, "R2 level");
    step(8'h40, 0, 8'h00, 1, "R2 ack");
    expect_ack(6, "R2");
    step(8'h40, 1, 8'h20, 0, "R2 eoi");
    expect_out(8'h00, 1, "R2 level request re-raises");
    idle(8'h00, "R2 level");
    expect_out(8'h00, 0, "R2 level request dropped");
    trig_level = 0;
    idle(8'h40, "R2 edge");
    step(8'h40, 0, 8'h00, 1, "R2 ack");
    step(8'h40, 1, 8'h20, 0, "R2 eoi");
    expect_out(8'h00, 0, "R2 held edge request not relatched");
    idle(8'h00, "R2");

    // random phase against the model
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] r, d;
      bit we, a;
      if (n % 60 == 0) begin
        trig_level = $urandom_range(0, 1);
        auto_eoi   = ($urandom_range(0, 3) == 0);
      end
      r  = 8'($urandom);
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 1) d[4:3] = 2'b00;
      we = ($urandom_range(0, 3) == 0);
      a  = ($urandom_range(0, 1) == 1);
      step(r, we, d, a, "R3 R4 R6 random");
    end

    done = 1;
    report();
    $finish;
  end

endmodule